// File: doc/BRIEF.md
# Per-Load Miss-Rate Allocation Filter

This block watches the hit/miss outcome of every data load, keyed by the load's program counter, and learns which load instructions miss often. It returns two hints for each lookup. The first tells the data cache whether the line for this access may be allocated. The second tells the prefetch engine whether a prefetch tied to this load may fetch the whole line or only the sector that holds the referenced word. One per-load flag drives both hints, so a load that streams through memory stops polluting the cache and cuts its prefetch traffic in the same step.

The history is held in a direct-mapped table indexed by low PC bits, with a partial PC tag in each entry. Each entry keeps a small saturating counter that rises on a miss and falls on a hit. A load is flagged when its counter exceeds a threshold set from outside the block. After a fixed number of lookups, every counter is halved, so the flags follow program phase changes. The table write-back is pipelined one cycle behind the lookup, and a lookup that meets a pending write takes the pending value.

Top module: `load_miss_filter`

## Requirements
- R1: After reset, rsp_valid is 0, rsp_alloc is 1, rsp_sector is 0 and every table entry is empty, so the first lookup of any PC gets the normal answer.
- R2: The answer for a request with req_valid high appears on the outputs exactly one clock later, with rsp_valid high in that cycle only.
- R3: A request uses PC bits [IDX_W+1:2] as the entry index and the next TAG_W bits above them as the tag. When the entry is empty or its tag differs, the answer is normal and the entry restarts with the new tag and a count of 1 after a miss or 0 after a hit.
- R4: On a tag match, a miss (req_miss=1) adds one to the count and a hit subtracts one. The count saturates at 0 and at 2^CTR_W-1.
- R5: The answer uses the count as it stood before this request's own update. If that count is greater than the miss_limit value presented with the request, rsp_alloc is 0 and rsp_sector is 1. Otherwise rsp_alloc is 1 and rsp_sector is 0.
- R6: After the update of every DECAY_N-th request since reset, every counter in the table is halved, rounding down. Tags and occupancy are kept.
- R7: A request in the cycle right after another request sees the earlier request's update, and any halving it triggered, even when both hit the same entry.
- R8: A cycle with req_valid low gives rsp_valid 0, rsp_alloc 1 and rsp_sector 0 on the next cycle. It changes no table entry and does not count toward the halving period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A load lookup is presented this cycle |
| req_pc | input | PC_W | Program counter of the load |
| req_miss | input | 1 | 1 if the load missed the data cache, 0 if it hit |
| miss_limit | input | CTR_W | Count above which a load is treated as high-missing |
| rsp_valid | output | 1 | Answer for the previous cycle's request |
| rsp_alloc | output | 1 | 1 lets the cache allocate the line, 0 forbids it |
| rsp_sector | output | 1 | 1 limits the related prefetch to one sector, 0 allows the full line |

## Verification
The bench compares every answer against an arithmetic model of the table. It first runs directed sequences and then sweeps all eight thresholds over traffic that mixes PCs aliasing on one index with idle gaps. Back-to-back requests to one entry catch a design that skips forwarding, which would answer from a stale count and flag one request late. Twelve misses followed by hits catch a counter that wraps instead of saturating: that counter would drop a flag too early or raise one after a run of hits. A probe right after the halving boundary catches an off-by-one period, or a halving that ignores the boundary request's own update. Idle gaps catch idle cycles counted toward the period. Two PCs that share an index with different tags catch a design that reuses a foreign count instead of starting the entry again.

// File: rtl/lmf_pkg.sv
package lmf_pkg;

    // Granularity of the prefetch tied to a load
    typedef enum logic {
        GRAIN_LINE   = 1'b0,
        GRAIN_SECTOR = 1'b1
    } grain_e;

endpackage

// File: rtl/lmf_pc_split.sv
module lmf_pc_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int TAG_W = 6
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);

    localparam int IDX_LO = 2;
    localparam int TAG_LO = IDX_LO + IDX_W;
    localparam int TOP_LO = TAG_LO + TAG_W;

    logic unused_pc_bits;

    assign idx = pc[TAG_LO-1:IDX_LO];
    assign tag = pc[TOP_LO-1:TAG_LO];

    generate
        if (TOP_LO < PC_W) begin : g_upper
            assign unused_pc_bits = ^{pc[PC_W-1:TOP_LO], pc[IDX_LO-1:0]};
        end else begin : g_noupper
            assign unused_pc_bits = ^pc[IDX_LO-1:0];
        end
    endgenerate

endmodule

// File: rtl/lmf_entry_store.sv
module lmf_entry_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 6,
    parameter int CTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic [CTR_W-1:0] wb_ctr,
    input  logic             wb_decay,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [CTR_W-1:0] rd_ctr
);

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [CTR_W-1:0] ctr;
    } ent_t;

    ent_t ent_d [ENTRIES];
    ent_t ent_q [ENTRIES];
    ent_t wb_ent;
    ent_t rd_ent;

    // Apply the pending write-back, then the pending halving
    function automatic ent_t fold(ent_t cur, logic take_wb, ent_t wb, logic halve);
        ent_t r;
        r = take_wb ? wb : cur;
        if (halve) begin
            r.ctr = r.ctr >> 1;
        end
        return r;
    endfunction

    always_comb begin
        wb_ent.vld = 1'b1;
        wb_ent.tag = wb_tag;
        wb_ent.ctr = wb_ctr;
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_d[i] = fold(ent_q[i], wb_en && (wb_idx == IDX_W'(i)), wb_ent, wb_decay);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    // Read port sees the write that has not reached the array yet
    always_comb begin
        rd_ent = fold(ent_q[rd_idx], wb_en && (wb_idx == rd_idx), wb_ent, wb_decay);
        rd_vld = rd_ent.vld;
        rd_tag = rd_ent.tag;
        rd_ctr = rd_ent.ctr;
    end

endmodule

// File: rtl/lmf_count_update.sv
module lmf_count_update #(
    parameter int TAG_W = 6,
    parameter int CTR_W = 3
) (
    input  logic             cur_vld,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic [CTR_W-1:0] cur_ctr,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_miss,
    input  logic [CTR_W-1:0] limit,
    output logic             flagged,
    output logic [CTR_W-1:0] new_ctr
);

    localparam logic [CTR_W-1:0] CTR_MAX = '1;
    localparam logic [CTR_W-1:0] CTR_ONE = CTR_W'(1);

    logic owned;

    always_comb begin
        owned   = cur_vld && (cur_tag == req_tag);
        flagged = owned && (cur_ctr > limit);
        if (!owned) begin
            new_ctr = req_miss ? CTR_ONE : '0;
        end else if (req_miss) begin
            new_ctr = (cur_ctr == CTR_MAX) ? CTR_MAX : cur_ctr + CTR_ONE;
        end else begin
            new_ctr = (cur_ctr == '0) ? '0 : cur_ctr - CTR_ONE;
        end
    end

endmodule

// File: rtl/lmf_decay_timer.sv
module lmf_decay_timer #(
    parameter int DECAY_N = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic fire
);

    localparam int CNT_W = (DECAY_N > 2) ? $clog2(DECAY_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DECAY_N - 1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        fire  = tick && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (tick) begin
            cnt_d = fire ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/load_miss_filter.sv
module load_miss_filter
    import lmf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 6,
    parameter int CTR_W   = 3,
    parameter int DECAY_N = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PC_W-1:0]  req_pc,
    input  logic             req_miss,
    input  logic [CTR_W-1:0] miss_limit,
    output logic             rsp_valid,
    output logic             rsp_alloc,
    output logic             rsp_sector
);

    typedef struct packed {
        logic             rsp_valid;
        grain_e           grain;
        logic             wb_en;
        logic [IDX_W-1:0] wb_idx;
        logic [TAG_W-1:0] wb_tag;
        logic [CTR_W-1:0] wb_ctr;
        logic             wb_decay;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             rd_vld;
    logic [TAG_W-1:0] rd_tag;
    logic [CTR_W-1:0] rd_ctr;
    logic             flagged;
    logic [CTR_W-1:0] new_ctr;
    logic             decay_fire;

    lmf_pc_split #(
        .PC_W  (PC_W),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_split (
        .pc  (req_pc),
        .idx (req_idx),
        .tag (req_tag)
    );

    lmf_entry_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .CTR_W (CTR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .wb_en    (st_q.wb_en),
        .wb_idx   (st_q.wb_idx),
        .wb_tag   (st_q.wb_tag),
        .wb_ctr   (st_q.wb_ctr),
        .wb_decay (st_q.wb_decay),
        .rd_vld   (rd_vld),
        .rd_tag   (rd_tag),
        .rd_ctr   (rd_ctr)
    );

    lmf_count_update #(
        .TAG_W (TAG_W),
        .CTR_W (CTR_W)
    ) u_update (
        .cur_vld  (rd_vld),
        .cur_tag  (rd_tag),
        .cur_ctr  (rd_ctr),
        .req_tag  (req_tag),
        .req_miss (req_miss),
        .limit    (miss_limit),
        .flagged  (flagged),
        .new_ctr  (new_ctr)
    );

    lmf_decay_timer #(
        .DECAY_N (DECAY_N)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (req_valid),
        .fire  (decay_fire)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.grain     = (req_valid && flagged) ? GRAIN_SECTOR : GRAIN_LINE;
        st_d.wb_en     = req_valid;
        st_d.wb_idx    = req_idx;
        st_d.wb_tag    = req_tag;
        st_d.wb_ctr    = new_ctr;
        st_d.wb_decay  = decay_fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.grain <= GRAIN_LINE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_sector = (st_q.grain == GRAIN_SECTOR);
    assign rsp_alloc  = (st_q.grain == GRAIN_LINE);

endmodule

// File: rtl/lmf_checker.sv
module lmf_checker #(
    parameter int PC_W  = 32,
    parameter int CTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [PC_W-1:0]  req_pc,
    input logic             req_miss,
    input logic [CTR_W-1:0] miss_limit,
    input logic             rsp_valid,
    input logic             rsp_alloc,
    input logic             rsp_sector
);

    // R2: a request is answered on the following cycle
    p_answer_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: no answer without a request in the previous cycle
    p_no_spurious_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: idle cycles give the normal hints
    p_idle_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_alloc && !rsp_sector));

    // R5: the largest threshold can never be exceeded by a saturating count
    p_top_limit_never_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (miss_limit == '1)) |=> !rsp_sector);

    // R4: a hit cannot raise a count that was not above the threshold
    p_hit_keeps_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid) && (req_pc == $past(req_pc)) &&
         !$past(req_miss) && (miss_limit == $past(miss_limit)) && !rsp_sector)
        |=> !rsp_sector);

endmodule

bind load_miss_filter lmf_checker #(
    .PC_W  (PC_W),
    .CTR_W (CTR_W)
) i_lmf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_pc     (req_pc),
    .req_miss   (req_miss),
    .miss_limit (miss_limit),
    .rsp_valid  (rsp_valid),
    .rsp_alloc  (rsp_alloc),
    .rsp_sector (rsp_sector)
);

// File: tb/test_load_miss_filter.sv
`timescale 1ns/1ps
module test_load_miss_filter;

    localparam int PC_W    = 32;
    localparam int IDX_W   = 4;
    localparam int TAG_W   = 6;
    localparam int CTR_W   = 3;
    localparam int DECAY_N = 16;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int CMAX    = (1 << CTR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [PC_W-1:0]  req_pc = '0;
    logic             req_miss = 1'b0;
    logic [CTR_W-1:0] miss_limit = '0;
    logic             rsp_valid;
    logic             rsp_alloc;
    logic             rsp_sector;

    always #2 clk = ~clk;

    load_miss_filter #(
        .PC_W    (PC_W),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .CTR_W   (CTR_W),
        .DECAY_N (DECAY_N)
    ) i_load_miss_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_pc     (req_pc),
        .req_miss   (req_miss),
        .miss_limit (miss_limit),
        .rsp_valid  (rsp_valid),
        .rsp_alloc  (rsp_alloc),
        .rsp_sector (rsp_sector)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit m_vld [ENTRIES];
    int m_tag [ENTRIES];
    int m_cnt [ENTRIES];
    int m_period;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] make_pc(input int idx, input int tag);
        return PC_W'((tag << (IDX_W + 2)) | (idx << 2));
    endfunction

    task automatic do_reset();
        rst_n     = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
            m_vld[i] = 0;
            m_tag[i] = 0;
            m_cnt[i] = 0;
        end
        m_period = 0;
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
        check(rsp_alloc == 1'b1, "R1", "rsp_alloc after reset", int'(rsp_alloc), 1);
        check(rsp_sector == 1'b0, "R1", "rsp_sector after reset", int'(rsp_sector), 0);
    endtask

    // Drive at a falling edge, read the answer at the next falling edge
    task automatic lookup(input logic [PC_W-1:0] pc, input bit miss, input string rq);
        int idx;
        int tag;
        bit own;
        bit expf;
        idx  = int'(pc[IDX_W+1:2]);
        tag  = int'(pc[IDX_W+TAG_W+1:IDX_W+2]);
        own  = m_vld[idx] && (m_tag[idx] == tag);
        expf = own && (m_cnt[idx] > int'(miss_limit));
        req_valid = 1'b1;
        req_pc    = pc;
        req_miss  = miss;
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b1, rq, "rsp_valid", int'(rsp_valid), 1);
        check(rsp_sector == expf, rq, "rsp_sector", int'(rsp_sector), int'(expf));
        check(rsp_alloc == !expf, rq, "rsp_alloc", int'(rsp_alloc), int'(!expf));
        if (!own) begin
            m_vld[idx] = 1;
            m_tag[idx] = tag;
            m_cnt[idx] = miss ? 1 : 0;
        end else if (miss) begin
            m_cnt[idx] = (m_cnt[idx] == CMAX) ? CMAX : m_cnt[idx] + 1;
        end else begin
            m_cnt[idx] = (m_cnt[idx] == 0) ? 0 : m_cnt[idx] - 1;
        end
        m_period++;
        if (m_period == DECAY_N) begin
            m_period = 0;
            for (int i = 0; i < ENTRIES; i++) m_cnt[i] = m_cnt[i] / 2;
        end
    endtask

    task automatic idle(input string rq);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, rq, "idle rsp_valid", int'(rsp_valid), 0);
        check(rsp_alloc == 1'b1, rq, "idle rsp_alloc", int'(rsp_alloc), 1);
        check(rsp_sector == 1'b0, rq, "idle rsp_sector", int'(rsp_sector), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        do_reset();

        // R3 cold entry, then R7 back-to-back misses raise the flag (R5)
        miss_limit = 3'd2;
        lookup(make_pc(3, 5), 1'b1, "R3");
        for (int k = 0; k < 4; k++) lookup(make_pc(3, 5), 1'b1, "R7");
        for (int k = 0; k < 3; k++) lookup(make_pc(3, 5), 1'b0, "R5");
        idle("R8");

        // R3 alias on the same index with another tag
        lookup(make_pc(3, 9), 1'b1, "R3");
        lookup(make_pc(3, 5), 1'b1, "R3");
        lookup(make_pc(3, 5), 1'b1, "R3");

        // R4 saturation at the top, then hits
        miss_limit = 3'd6;
        for (int k = 0; k < 12; k++) lookup(make_pc(7, 2), 1'b1, "R4");
        for (int k = 0; k < 3; k++) lookup(make_pc(7, 2), 1'b0, "R4");
        for (int k = 0; k < 10; k++) lookup(make_pc(7, 2), 1'b0, "R4");
        lookup(make_pc(7, 2), 1'b0, "R4");

        // R6 halving boundary, with idle cycles that must not count (R8)
        do_reset();
        miss_limit = 3'd1;
        for (int k = 0; k < 3; k++) lookup(make_pc(1, 4), 1'b1, "R6");
        idle("R8");
        idle("R8");
        for (int k = 0; k < 13; k++) lookup(make_pc(2, 4), 1'b0, "R6");
        lookup(make_pc(1, 4), 1'b1, "R6");
        lookup(make_pc(1, 4), 1'b1, "R6");

        // R5 sweep over every threshold with aliasing PCs and gaps
        r = 16'hACE1;
        for (int lim = 0; lim <= CMAX; lim++) begin
            miss_limit = CTR_W'(lim);
            for (int k = 0; k < 160; k++) begin
                int idx;
                int tag;
                bit miss;
                r    = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
                idx  = int'(r[1:0]);
                tag  = r[2] ? 3 : 12;
                miss = (idx < 2) ? (r[7:5] != 3'd0) : (r[7:5] == 3'd0);
                if (r[9:8] == 2'd0) idle("R8");
                lookup(make_pc(idx, tag), miss, "R5");
            end
        end

        // R1 reset clears learned state
        do_reset();
        miss_limit = 3'd0;
        lookup(make_pc(0, 3), 1'b1, "R1");
        lookup(make_pc(0, 3), 1'b1, "R2");
        idle("R2");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule